// File: doc/BRIEF.md
# Multi-Mode Data Address Generator

This block turns one instruction operand into a memory address. It takes an addressing mode, a constant or short offset, a pointer select and a post-modify code. From these it produces, in the same cycle, a 23-bit data-space address or a 16-bit I/O address, together with a flag that names the space. Six modes are supported. Two of them take the address from a constant: a 16-bit constant placed under a 7-bit page-high register, or a full 23-bit constant. A third gives a 16-bit I/O address from a constant. The remaining modes are direct addressing from a page or stack base, direct I/O addressing from a peripheral page, and indirect addressing through one of eight 16-bit pointer registers.

A status input chooses the base for direct addressing. When it is low, the data page register is the base and the page-high register extends the address. When it is high, the stack pointer is the base and the stack-high register extends the address. In indirect mode the selected pointer supplies the address before it is modified. The modified pointer is driven out and written back at the clock edge that ends the cycle. The modification is linear, or circular within a buffer given by a start register and a size register. The base and pointer registers are loaded through a simple register write port.

Top module: `data_addr_gen`

## Requirements
- R1: After reset every base, extension, buffer and pointer register is zero. For example, a k16 access with constant K then yields address K, and any indirect access yields address 0.
- R2: Mode 0 (k16 absolute) drives address = {pageHigh[6:0], operand[15:0]} with ioSel = 0.
- R3: Mode 1 (k23 absolute) drives address = operand[22:0] with ioSel = 0.
- R4: Mode 2 (I/O absolute) drives address = {7'b0, operand[15:0]} with ioSel = 1.
- R5: Mode 3 (direct) with stackMode = 0 drives address = {pageHigh, (DP + operand[6:0]) mod 2^16} with ioSel = 0.
- R6: Mode 3 (direct) with stackMode = 1 drives address = {stackHigh, (SP + operand[6:0]) mod 2^16} with ioSel = 0.
- R7: Mode 4 (peripheral direct) drives address = {7'b0, PDP[8:0], operand[6:0]} with ioSel = 1, whatever the value of stackMode.
- R8: Mode 5 (indirect) drives address = {pageHigh, AR[arSel]} with ioSel = 0. The address is the pointer value before modification.
- R9: When circ = 0, indirect ptrNew = AR[arSel] + step mod 2^16. The step is 0, +1, -1 or +AR0 for modifier codes 0, 1, 2 and 3. When opValid = 1 and the modifier is not 0, the pointer takes ptrNew at the clock edge, so the next access sees it.
- R10: When circ = 1, ptrNew = start + ((AR - start + step) wrapped into 0..size-1). This assumes 1 <= size, a pointer already inside the buffer, and a step magnitude no larger than size.
- R11: Register write port codes: regSel 0..7 selects AR0..AR7, 8 DP, 9 SP, 10 PDP (low 9 bits), 11 pageHigh (low 7 bits), 12 stackHigh (low 7 bits), 13 buffer start, 14 buffer size. A register write to the pointer being post-modified in the same cycle takes priority.
- R12: No pointer changes when opValid = 0 or when the mode is not indirect. Reserved modes 6 and 7 drive address 0 with ioSel = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operand access this cycle; enables pointer write-back |
| mode | input | 3 | Addressing mode code (0..5, 6 and 7 reserved) |
| stackMode | input | 1 | Direct base select: 0 data page, 1 stack pointer |
| circ | input | 1 | Circular post-modification for indirect mode |
| modifier | input | 2 | Post-modify code: none, +1, -1, +AR0 |
| arSel | input | 3 | Pointer register select for indirect mode |
| operand | input | 23 | Constant or offset (offset uses bits 6:0) |
| regWe | input | 1 | Register write strobe |
| regSel | input | 4 | Register write target code |
| regData | input | 16 | Register write data |
| addr | output | 23 | Generated address (I/O addresses in bits 15:0) |
| ioSel | output | 1 | 1 selects I/O space, 0 data space |
| ptrNew | output | 16 | Modified pointer value for indirect mode |

## Verification
The checker assumes that reset stays asserted for at least one clock edge and that opValid is low during reset. It also assumes that two back-to-back indirect accesses to the same pointer carry no register write in between. The linear post-modify properties are conditioned on circ = 0, because the circular result is only defined for an in-buffer pointer with a step no larger than the buffer size. The bench keeps every circular sweep to a buffer it has loaded first. It starts the pointer inside that buffer and sets AR0 below the size before it uses the +AR0 step.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int ADDR_W  = 23;
  localparam int WORD_W  = 16;
  localparam int PAGE_W  = ADDR_W - WORD_W;
  localparam int OFS_W   = 7;
  localparam int PDP_W   = WORD_W - OFS_W;
  localparam int NUM_AR  = 8;
  localparam int SEL_W   = $clog2(NUM_AR);
  localparam int RSEL_W  = 4;
  localparam int EXT_W   = WORD_W + 2;

  localparam logic [RSEL_W-1:0] RS_DP      = RSEL_W'(NUM_AR);
  localparam logic [RSEL_W-1:0] RS_SP      = RSEL_W'(NUM_AR + 1);
  localparam logic [RSEL_W-1:0] RS_PDP     = RSEL_W'(NUM_AR + 2);
  localparam logic [RSEL_W-1:0] RS_PAGEHI  = RSEL_W'(NUM_AR + 3);
  localparam logic [RSEL_W-1:0] RS_STACKHI = RSEL_W'(NUM_AR + 4);
  localparam logic [RSEL_W-1:0] RS_CBSTART = RSEL_W'(NUM_AR + 5);
  localparam logic [RSEL_W-1:0] RS_CBSIZE  = RSEL_W'(NUM_AR + 6);

  typedef enum logic [2:0] {
    MODE_ABS16    = 3'd0,
    MODE_ABS23    = 3'd1,
    MODE_IOABS    = 3'd2,
    MODE_DIRECT   = 3'd3,
    MODE_PERIPH   = 3'd4,
    MODE_INDIRECT = 3'd5,
    MODE_RSV6     = 3'd6,
    MODE_RSV7     = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    MOD_NONE = 2'd0,
    MOD_INC  = 2'd1,
    MOD_DEC  = 2'd2,
    MOD_AR0  = 2'd3
  } modif_e;

  typedef struct packed {
    logic selAbs16;
    logic selAbs23;
    logic selIoAbs;
    logic selDpDir;
    logic selSpDir;
    logic selPeriph;
    logic selInd;
    logic ptrWrite;
  } dag_strobes_t;
endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
(
  input  logic         opValid,
  input  logic [2:0]   mode,
  input  logic         stackMode,
  input  logic [1:0]   modifier,
  output dag_strobes_t strobe
);
  always_comb begin
    strobe = '0;
    case (mode_e'(mode))
      MODE_ABS16:    strobe.selAbs16  = 1'b1;
      MODE_ABS23:    strobe.selAbs23  = 1'b1;
      MODE_IOABS:    strobe.selIoAbs  = 1'b1;
      MODE_DIRECT: begin
        strobe.selDpDir = ~stackMode;
        strobe.selSpDir = stackMode;
      end
      MODE_PERIPH:   strobe.selPeriph = 1'b1;
      MODE_INDIRECT: begin
        strobe.selInd   = 1'b1;
        strobe.ptrWrite = opValid && (modif_e'(modifier) != MOD_NONE);
      end
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/dag_path.sv
module dag_path
  import dag_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dag_strobes_t        strobe,
  input  logic                circ,
  input  logic [1:0]          modifier,
  input  logic [SEL_W-1:0]    arSel,
  input  logic [ADDR_W-1:0]   operand,
  input  logic                regWe,
  input  logic [RSEL_W-1:0]   regSel,
  input  logic [WORD_W-1:0]   regData,
  output logic [ADDR_W-1:0]   addr,
  output logic                ioSel,
  output logic [WORD_W-1:0]   ptrNew
);
  logic [WORD_W-1:0] arReg [NUM_AR];
  logic [WORD_W-1:0] dpReg, spReg, cbStart, cbSize;
  logic [PDP_W-1:0]  pdpReg;
  logic [PAGE_W-1:0] pageHi, stackHi;

  // Pointer file: a register write wins over a post-modify write-back
  generate
    for (genvar gi = 0; gi < NUM_AR; gi++) begin : g_ar
      always_ff @(posedge clk) begin
        if (!rstN)
          arReg[gi] <= '0;
        else if (regWe && regSel == RSEL_W'(gi))
          arReg[gi] <= regData;
        else if (strobe.ptrWrite && arSel == SEL_W'(gi))
          arReg[gi] <= ptrNew;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dpReg   <= '0;
      spReg   <= '0;
      pdpReg  <= '0;
      pageHi  <= '0;
      stackHi <= '0;
      cbStart <= '0;
      cbSize  <= '0;
    end else if (regWe) begin
      case (regSel)
        RS_DP:      dpReg   <= regData;
        RS_SP:      spReg   <= regData;
        RS_PDP:     pdpReg  <= regData[PDP_W-1:0];
        RS_PAGEHI:  pageHi  <= regData[PAGE_W-1:0];
        RS_STACKHI: stackHi <= regData[PAGE_W-1:0];
        RS_CBSTART: cbStart <= regData;
        RS_CBSIZE:  cbSize  <= regData;
        default: ;
      endcase
    end
  end

  // Post-modification
  logic [WORD_W-1:0] ptrCur, relOfs, linNext, circNext;
  logic [EXT_W-1:0]  stepExt, relSum, relWrap;

  always_comb begin
    ptrCur = arReg[arSel];
    case (modif_e'(modifier))
      MOD_INC: stepExt = EXT_W'(1);
      MOD_DEC: stepExt = '1;
      MOD_AR0: stepExt = {2'b00, arReg[0]};
      default: stepExt = '0;
    endcase
    linNext = ptrCur + stepExt[WORD_W-1:0];
    relOfs  = ptrCur - cbStart;
    relSum  = {2'b00, relOfs} + stepExt;
    if (relSum[EXT_W-1])
      relWrap = relSum + {2'b00, cbSize};
    else if (relSum[WORD_W:0] >= {1'b0, cbSize})
      relWrap = relSum - {2'b00, cbSize};
    else
      relWrap = relSum;
    circNext = cbStart + relWrap[WORD_W-1:0];
    ptrNew   = circ ? circNext : linNext;
  end

  // Address formation
  logic [OFS_W-1:0]  ofs;
  logic [WORD_W-1:0] dpSum, spSum;

  always_comb begin
    ofs   = operand[OFS_W-1:0];
    dpSum = dpReg + WORD_W'(ofs);
    spSum = spReg + WORD_W'(ofs);
    addr  = '0;
    ioSel = 1'b0;
    if (strobe.selAbs16) begin
      addr = {pageHi, operand[WORD_W-1:0]};
    end else if (strobe.selAbs23) begin
      addr = operand;
    end else if (strobe.selIoAbs) begin
      addr  = {{PAGE_W{1'b0}}, operand[WORD_W-1:0]};
      ioSel = 1'b1;
    end else if (strobe.selDpDir) begin
      addr = {pageHi, dpSum};
    end else if (strobe.selSpDir) begin
      addr = {stackHi, spSum};
    end else if (strobe.selPeriph) begin
      addr  = {{PAGE_W{1'b0}}, pdpReg, ofs};
      ioSel = 1'b1;
    end else if (strobe.selInd) begin
      addr = {pageHi, ptrCur};
    end
  end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
  import dag_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2:0]          mode,
  input  logic                stackMode,
  input  logic                circ,
  input  logic [1:0]          modifier,
  input  logic [SEL_W-1:0]    arSel,
  input  logic [ADDR_W-1:0]   operand,
  input  logic                regWe,
  input  logic [RSEL_W-1:0]   regSel,
  input  logic [WORD_W-1:0]   regData,
  output logic [ADDR_W-1:0]   addr,
  output logic                ioSel,
  output logic [WORD_W-1:0]   ptrNew
);
  dag_strobes_t strobe;

  dag_ctrl u_ctrl (
    .opValid   (opValid),
    .mode      (mode),
    .stackMode (stackMode),
    .modifier  (modifier),
    .strobe    (strobe)
  );

  dag_path u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .circ     (circ),
    .modifier (modifier),
    .arSel    (arSel),
    .operand  (operand),
    .regWe    (regWe),
    .regSel   (regSel),
    .regData  (regData),
    .addr     (addr),
    .ioSel    (ioSel),
    .ptrNew   (ptrNew)
  );
endmodule

// File: rtl/data_addr_gen_chk.sv
module data_addr_gen_chk
  import dag_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        mode,
  input logic              circ,
  input logic [1:0]        modifier,
  input logic [SEL_W-1:0]  arSel,
  input logic [ADDR_W-1:0] operand,
  input logic              regWe,
  input logic [ADDR_W-1:0] addr,
  input logic              ioSel,
  input logic [WORD_W-1:0] ptrNew
);
  // R2: low half of a k16 address is the constant
  p_abs16_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd0) |-> (addr[WORD_W-1:0] == operand[WORD_W-1:0] && !ioSel));

  // R3: full constant passes through
  p_abs23_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd1) |-> (addr == operand && !ioSel));

  // R4: I/O constant selects I/O space with a clear upper part
  p_ioabs_space_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2) |-> (ioSel && addr[ADDR_W-1:WORD_W] == '0));

  // R7: peripheral direct keeps the offset in the low bits
  p_periph_ofs_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd4) |-> (ioSel && addr[OFS_W-1:0] == operand[OFS_W-1:0]
                        && addr[ADDR_W-1:WORD_W] == '0));

  // R9: linear increment and decrement relative to the issued address
  p_lin_inc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd5 && !circ && modifier == 2'd1) |->
      (ptrNew == addr[WORD_W-1:0] + WORD_W'(1)));

  p_lin_dec_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd5 && !circ && modifier == 2'd2) |->
      (ptrNew == addr[WORD_W-1:0] - WORD_W'(1)));

  // R9: write-back visible to the next access of the same pointer
  p_wb_next_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && mode == 3'd5 && arSel == $past(arSel)
     && $past(opValid && mode == 3'd5 && !regWe && rstN)) |->
      (addr[WORD_W-1:0] == $past(ptrNew)));

  // R12: reserved modes drive nothing
  p_rsv_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd6 || mode == 3'd7) |-> (addr == '0 && !ioSel));
endmodule

bind data_addr_gen data_addr_gen_chk u_chk (.*);

// File: tb/data_addr_gen_test.sv
module data_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [2:0]  mode;
  logic        stackMode;
  logic        circ;
  logic [1:0]  modifier;
  logic [2:0]  arSel;
  logic [22:0] operand;
  logic        regWe;
  logic [3:0]  regSel;
  logic [15:0] regData;
  logic [22:0] addr;
  logic        ioSel;
  logic [15:0] ptrNew;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mAr [8];
  logic [15:0] mDp, mSp, mStart, mSize;
  logic [8:0]  mPdp;
  logic [6:0]  mPh, mSh;

  always #(CLK_PERIOD/2) clk = ~clk;

  data_addr_gen uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .mode(mode),
    .stackMode(stackMode), .circ(circ), .modifier(modifier), .arSel(arSel),
    .operand(operand), .regWe(regWe), .regSel(regSel), .regData(regData),
    .addr(addr), .ioSel(ioSel), .ptrNew(ptrNew)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [15:0] d);
    @(negedge clk);
    opValid = 0; regWe = 1; regSel = sel; regData = d;
    @(posedge clk); #1;
    regWe = 0;
    if (sel < 8) mAr[sel] = d;
    else case (sel)
      4'd8:  mDp = d;
      4'd9:  mSp = d;
      4'd10: mPdp = d[8:0];
      4'd11: mPh = d[6:0];
      4'd12: mSh = d[6:0];
      4'd13: mStart = d;
      4'd14: mSize = d;
      default: ;
    endcase
  endtask

  // Drive one operand in the low phase; outputs are checked before the next edge
  task automatic op(input logic v, input logic [2:0] m, input logic sm, input logic c,
                    input logic [1:0] md, input logic [2:0] s, input logic [22:0] o);
    @(negedge clk);
    regWe = 0; opValid = v; mode = m; stackMode = sm; circ = c;
    modifier = md; arSel = s; operand = o;
    #2;
  endtask

  function automatic int stepOf(input logic [1:0] md);
    case (md)
      2'd1: return 1;
      2'd2: return -1;
      2'd3: return int'(mAr[0]);
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] nextPtr(input logic [15:0] p, input logic c, input logic [1:0] md);
    int st = stepOf(md);
    if (!c) return 16'((int'(p) + st) & 'hFFFF);
    begin
      int rel = (int'(p) - int'(mStart)) & 'hFFFF;
      int n = rel + st;
      if (n < 0) n += int'(mSize);
      else if (n >= int'(mSize)) n -= int'(mSize);
      return 16'((int'(mStart) + n) & 'hFFFF);
    end
  endfunction

  // Indirect access with model update at the ending edge
  task automatic indOp(input string req, input logic c, input logic [1:0] md, input logic [2:0] s);
    logic [15:0] expN;
    op(1, 3'd5, 0, c, md, s, '0);
    expN = nextPtr(mAr[s], c, md);
    chk({req, " addr"}, 32'(addr), 32'({mPh, mAr[s]}));
    chk({req, " ptrNew"}, 32'(ptrNew), 32'(expN));
    if (md != 2'd0) mAr[s] = expN;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; opValid = 0; mode = 0; stackMode = 0; circ = 0; modifier = 0;
    arSel = 0; operand = 0; regWe = 0; regSel = 0; regData = 0;
    foreach (mAr[i]) mAr[i] = 0;
    mDp = 0; mSp = 0; mStart = 0; mSize = 0; mPdp = 0; mPh = 0; mSh = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: reset state seen through k16 and indirect accesses
    op(0, 3'd0, 0, 0, 0, 0, 23'h00_1234);
    chk("R1 reset pageHigh", 32'(addr), 32'h1234);
    for (int s = 0; s < 8; s++) begin
      op(0, 3'd5, 0, 0, 0, 3'(s), '0);
      chk("R1 reset pointer", 32'(addr), 32'h0);
    end

    // R2: k16 over several page-high values and constants
    for (int p = 0; p < 128; p += 21) begin
      wr(4'd11, 16'(p));
      for (int k = 0; k < 65536; k += 9973) begin
        op(1, 3'd0, 0, 0, 0, 0, 23'(k) | 23'h7F_0000);
        chk("R2 k16 addr", 32'(addr), 32'({7'(p), 16'(k)}));
        chk("R2 k16 space", 32'(ioSel), 0);
      end
    end

    // R3 / R4: absolute constants
    for (int k = 0; k < (1 << 23); k += 611953) begin
      op(1, 3'd1, 0, 0, 0, 0, 23'(k));
      chk("R3 k23 addr", 32'({ioSel, addr}), 32'(k));
      op(1, 3'd2, 0, 0, 0, 0, 23'(k));
      chk("R4 io addr", 32'({ioSel, addr}), 32'({1'b1, 7'b0, 16'(k)}));
    end

    // R5 / R6: direct modes swept over every offset, bases near wrap
    wr(4'd8, 16'hFFC0); wr(4'd9, 16'h7FA0); wr(4'd11, 16'h0055); wr(4'd12, 16'h002A);
    for (int o = 0; o < 128; o++) begin
      op(1, 3'd3, 0, 0, 0, 0, 23'(o) | 23'h1F_FF80);
      chk("R5 dp direct", 32'({ioSel, addr}), 32'({1'b0, mPh, 16'(int'(mDp) + o)}));
      op(1, 3'd3, 1, 0, 0, 0, 23'(o));
      chk("R6 sp direct", 32'({ioSel, addr}), 32'({1'b0, mSh, 16'(int'(mSp) + o)}));
    end
    wr(4'd9, 16'hFFFF);
    op(1, 3'd3, 1, 0, 0, 0, 23'd1);
    chk("R6 sp wrap", 32'(addr), 32'({mSh, 16'h0000}));

    // R7: peripheral direct ignores stackMode
    for (int p = 0; p < 512; p += 73) begin
      wr(4'd10, 16'hFE00 | 16'(p));
      for (int o = 0; o < 128; o += 31) begin
        for (int sm = 0; sm < 2; sm++) begin
          op(1, 3'd4, 1'(sm), 0, 0, 0, 23'(o));
          chk("R7 periph", 32'({ioSel, addr}), 32'({1'b1, 7'b0, 9'(p), 7'(o)}));
        end
      end
    end

    // R11 / R8 / R9: load all pointers, then linear post-modify sweep
    wr(4'd11, 16'h0003);
    for (int s = 0; s < 8; s++) wr(4'(s), 16'(s * 16'h2001 + 16'hFFFE));
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 8; s++)
        for (int md = 0; md < 4; md++)
          indOp("R9 linear", 0, 2'(md), 3'(s));
    wr(4'd0, 16'h0000);
    indOp("R9 dec wrap", 0, 2'd2, 3'd0);
    indOp("R8 after wrap", 0, 2'd0, 3'd0);

    // R10: circular buffer start 0x0100, size 5
    wr(4'd13, 16'h0100); wr(4'd14, 16'd5); wr(4'd2, 16'h0102);
    for (int i = 0; i < 12; i++) indOp("R10 circ inc", 1, 2'd1, 3'd2);
    for (int i = 0; i < 12; i++) indOp("R10 circ dec", 1, 2'd2, 3'd2);
    wr(4'd0, 16'd3);
    for (int i = 0; i < 10; i++) indOp("R10 circ ar0", 1, 2'd3, 3'd2);
    wr(4'd2, 16'h0100);
    indOp("R10 circ low edge", 1, 2'd2, 3'd2);
    chk("R10 wrap to top", 32'(mAr[2]), 32'h0104);

    // R11: register write wins over post-modify on the same pointer
    wr(4'd3, 16'h1000);
    @(negedge clk);
    opValid = 1; mode = 3'd5; circ = 0; modifier = 2'd1; arSel = 3'd3;
    regWe = 1; regSel = 4'd3; regData = 16'hABCD;
    @(posedge clk); #1;
    regWe = 0; mAr[3] = 16'hABCD;
    op(1, 3'd5, 0, 0, 0, 3'd3, '0);
    chk("R11 write priority", 32'(addr[15:0]), 32'hABCD);

    // R12: no write-back without opValid or outside indirect mode
    wr(4'd5, 16'h4444);
    op(0, 3'd5, 0, 0, 2'd1, 3'd5, '0);
    op(1, 3'd0, 0, 0, 2'd1, 3'd5, '0);
    op(1, 3'd5, 0, 0, 2'd0, 3'd5, '0);
    chk("R12 pointer unchanged", 32'(addr[15:0]), 32'h4444);
    op(1, 3'd6, 0, 0, 0, 0, 23'h7F_FFFF);
    chk("R12 reserved 6", 32'({ioSel, addr}), 0);
    op(1, 3'd7, 1, 1, 3, 7, 23'h12_3456);
    chk("R12 reserved 7", 32'({ioSel, addr}), 0);

    @(negedge clk);
    opValid = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule